// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block turns single load and store requests from a processor core into bus cycles on a shared 16-bit address/data bus. Every cycle first places the address on the AD lines, then reuses those same lines for data. The core asks for a byte or a word, a read or a write, in either memory space (20-bit byte address) or I/O space (16-bit byte address). It gets one acknowledge when the whole access is done. On the bus side the block drives the AD lanes with an output enable, the upper address lines and an active-low byte-high enable. It also drives a two-bit cycle status, an address latch enable, separate active-low read and write strobes and an active-low data enable. It samples a ready input to stretch cycles.

Storage sits in two interleaved 8-bit banks. The even bank is on AD[7:0] and the odd bank is on AD[15:8]. The block contains its own address latch, loaded while the address latch enable is high, so both banks see a stable non-multiplexed address and byte-high enable for the rest of the cycle. A word that starts on an odd address is carried as two byte cycles, and the core still sees a single completion.

Each cycle walks through the states `S_IDLE`, `S_T1`, `S_T2`, `S_T3` and `S_T4`:
- `S_IDLE` moves to `S_T1` when a request is present.
- `S_T1` moves to `S_T2`, and `S_T2` moves to `S_T3`.
- `S_T3` stays in `S_T3` while ready is low and moves to `S_T4` when ready is high.
- `S_T4` moves back to `S_T1` to run the second half of a split word, and otherwise returns to `S_IDLE`.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is held and afterwards until a request arrives, the outputs are idle: `ale`=0, `ad_oe`=0, `ack`=0, and `rd_n`, `wr_n`, `den_n`, `bhe_n` are all 1.
- R2: In `S_T1` the block drives `ale`=1 and `ad_oe`=1 with the cycle address on {`a_hi`,`ad_out`}, and `rd_n`, `wr_n` and `den_n` are all high. A strobe first goes low in `S_T2`, never in `S_T1`, and the read and write strobes are never low together.
- R3: The strobe stays low through `S_T2` and every `S_T3`. `S_T3` repeats while `ready`=0, so a cycle that sees W clocks of `ready`=0 in `S_T3` holds its strobe low for W+2 clocks.
- R4: On a read, `ad_oe` is 0 from `S_T2` to the end of the cycle. On a write, the data is driven in `S_T2` and `S_T3`, and `ad_oe` falls in `S_T4`.
- R5: `lat_addr` and `lat_bhe_n` take {`a_hi`,`ad_out`} and `bhe_n` at the clock edge that ends `S_T1`. They then hold until the next `S_T1`.
- R6: On I/O cycles (`req_io`=1) bits 19:16 of the address are forced to zero. The address offset wraps within 16 bits, and status `st_io` is 1 during `S_T1` to `S_T3`. `st_wr` is 1 in the same states for writes.
- R7: Lane selection uses A0 and `bhe_n`: A0=0 with `bhe_n`=0 is a word on both lanes, A0=0 with `bhe_n`=1 is the even byte only, and A0=1 with `bhe_n`=0 is the odd byte only. A0=1 with `bhe_n`=1 never appears.
- R8: A byte write drives the byte on both lanes as {b,b}, so an odd-address byte reaches AD[15:8]. An aligned word write drives `req_wdata` unchanged.
- R9: A byte read returns {8'h00, byte}, taking AD[15:8] for an odd address and AD[7:0] for an even one.
- R10: A word at an odd address A becomes two cycles. The first is at A with `bhe_n`=0 and carries data bits 7:0 on the upper lane. The second is at A+1, wrapping within the space, with `bhe_n`=1 and data bits 15:8 on the lower lane. A read assembles the two halves into `rdata`.
- R11: `ack` is high for exactly one clock, in `S_T4` of the final cycle, once per request, and `rdata` is valid in that clock.
- R12: A request raised while a transfer is in progress is ignored, even if it stays raised. It starts no bus cycle and does not change the transfer in flight.
- R13: `den_n` is low exactly when a strobe is low, in `S_T2` and `S_T3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Core request, taken only in S_IDLE |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| ad_out | output | 16 | Multiplexed address/data lanes, outgoing |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 16 | Multiplexed lanes, incoming read data |
| a_hi | output | ADDR_W-IO_ADDR_W | Upper address lines |
| bhe_n | output | 1 | Byte-high enable, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable, active low |
| st_io | output | 1 | Status: I/O cycle |
| st_wr | output | 1 | Status: write cycle |
| ready | input | 1 | Cycle may end when high in S_T3 |
| lat_addr | output | ADDR_W | Latched, demultiplexed address |
| lat_bhe_n | output | 1 | Latched byte-high enable |

## Verification
The bench puts a two-bank byte memory behind the latched address and compares every access with a flat reference memory. It logs each bus cycle's address, lane code, status, write lanes and strobe length, so a design that lets a misaligned word go out as one cycle, or in the wrong order, shows up as wrong bytes or a wrong cycle count. A design that sends an odd byte to the lower lane corrupts the odd bank, and one that does not shift the odd read byte down returns wrong `rdata`. Wrap cases at the top of memory and of I/O space catch an I/O split that leaks a carry into the upper bits. Requests held high during a transfer catch a controller that queues them. Random wait states catch a strobe released early or a cycle that ignores `ready`.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_T1,
        S_T2,
        S_T3,
        S_T4
    } phase_t;
endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   ready,
    input  logic   is_write,
    input  logic   split,
    output phase_t state,
    output logic   second,
    output logic   accept,
    output logic   capture,
    output logic   done,
    output logic   ale,
    output logic   rd_n,
    output logic   wr_n,
    output logic   den_n,
    output logic   ad_oe,
    output logic   st_active
);
    phase_t state_d;
    logic   second_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            second <= 1'b0;
        end else begin
            state  <= state_d;
            second <= second_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state;
        second_d = second;
        unique case (state)
            S_IDLE: begin
                second_d = 1'b0;
                if (req) state_d = S_T1;
            end
            S_T1: state_d = S_T2;
            S_T2: state_d = S_T3;
            S_T3: if (ready) state_d = S_T4;
            S_T4: begin
                if (split && !second) begin
                    state_d  = S_T1;
                    second_d = 1'b1;
                end else begin
                    state_d  = S_IDLE;
                    second_d = 1'b0;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        capture   = 1'b0;
        done      = 1'b0;
        ale       = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        den_n     = 1'b1;
        ad_oe     = 1'b0;
        st_active = 1'b0;
        unique case (state)
            S_IDLE: accept = req;
            S_T1: begin
                ale       = 1'b1;
                ad_oe     = 1'b1;
                st_active = 1'b1;
            end
            S_T2, S_T3: begin
                st_active = 1'b1;
                den_n     = 1'b0;
                rd_n      = is_write;
                wr_n      = !is_write;
                ad_oe     = is_write;
                capture   = (state == S_T3) && ready && !is_write;
            end
            S_T4: done = !split || second;
            default: ;
        endcase
    end

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_T3 && !ready) |=> (state == S_T3));

    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_split_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_T4 && split && !second) |=> (state == S_T1 && second));
endmodule

// File: rtl/mbc_lane_steer.sv
module mbc_lane_steer
    import mbc_pkg::*;
(
    input  logic              a0,
    input  logic              aligned_word,
    input  logic [LANE_W-1:0] wbyte,
    input  logic [BUS_W-1:0]  wword,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              bhe_n,
    output logic [BUS_W-1:0]  wlanes,
    output logic [LANE_W-1:0] rbyte
);
    // upper lane is enabled for any word or for an odd byte
    always_comb begin
        bhe_n  = !(aligned_word || a0);
        wlanes = aligned_word ? wword : {wbyte, wbyte};
        rbyte  = a0 ? bus_in[BUS_W-1:LANE_W] : bus_in[LANE_W-1:0];
    end
endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch #(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ale,
    input  logic [ADDR_W-LOW_W-1:0] hi_in,
    input  logic [LOW_W-1:0]        low_in,
    input  logic                    bhe_n_in,
    output logic [ADDR_W-1:0]       lat_addr,
    output logic                    lat_bhe_n
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_bhe_n <= 1'b1;
        end else if (ale) begin
            lat_addr  <= {hi_in, low_in};
            lat_bhe_n <= bhe_n_in;
        end
    end

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> ($stable(lat_addr) && $stable(lat_bhe_n)));
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int IO_ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        req_wr,
    input  logic                        req_io,
    input  logic                        req_word,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [15:0]                 req_wdata,
    output logic                        ack,
    output logic [15:0]                 rdata,
    output logic [15:0]                 ad_out,
    output logic                        ad_oe,
    input  logic [15:0]                 ad_in,
    output logic [ADDR_W-IO_ADDR_W-1:0] a_hi,
    output logic                        bhe_n,
    output logic                        ale,
    output logic                        rd_n,
    output logic                        wr_n,
    output logic                        den_n,
    output logic                        st_io,
    output logic                        st_wr,
    input  logic                        ready,
    output logic [ADDR_W-1:0]           lat_addr,
    output logic                        lat_bhe_n
);
    localparam int HI_W = ADDR_W - IO_ADDR_W;

    phase_t            state;
    logic              second, accept, capture, done, st_active;
    logic              q_wr, q_io, q_word;
    logic [ADDR_W-1:0] q_addr, nxt_addr, cur_addr;
    logic [BUS_W-1:0]  q_wdata, rd_q, wlanes;
    logic [LANE_W-1:0] wbyte, rbyte;
    logic              misal, aligned_word, lane_bhe_n;

    assign misal        = q_word && q_addr[0];
    assign aligned_word = q_word && !q_addr[0];

    mbc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .ready    (ready),
        .is_write (q_wr),
        .split    (misal),
        .state    (state),
        .second   (second),
        .accept   (accept),
        .capture  (capture),
        .done     (done),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .den_n    (den_n),
        .ad_oe    (ad_oe),
        .st_active(st_active)
    );

    // request capture; I/O addresses lose their upper bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_wr    <= 1'b0;
            q_io    <= 1'b0;
            q_word  <= 1'b0;
            q_wdata <= '0;
        end else if (accept) begin
            q_addr  <= req_io ? {{HI_W{1'b0}}, req_addr[IO_ADDR_W-1:0]} : req_addr;
            q_wr    <= req_wr;
            q_io    <= req_io;
            q_word  <= req_word;
            q_wdata <= req_wdata;
        end
    end

    // address of the second half of a split word, wrapping inside its space
    always_comb begin
        if (q_io)
            nxt_addr = {{HI_W{1'b0}}, q_addr[IO_ADDR_W-1:0] + IO_ADDR_W'(1)};
        else
            nxt_addr = q_addr + ADDR_W'(1);
        cur_addr = second ? nxt_addr : q_addr;
        wbyte    = (misal && second) ? q_wdata[BUS_W-1:LANE_W] : q_wdata[LANE_W-1:0];
    end

    mbc_lane_steer u_lanes (
        .a0          (cur_addr[0]),
        .aligned_word(aligned_word),
        .wbyte       (wbyte),
        .wword       (q_wdata),
        .bus_in      (ad_in),
        .bhe_n       (lane_bhe_n),
        .wlanes      (wlanes),
        .rbyte       (rbyte)
    );

    // bus pins
    always_comb begin
        if (state == S_T1)
            ad_out = cur_addr[IO_ADDR_W-1:0];
        else if (ad_oe)
            ad_out = wlanes;
        else
            ad_out = '0;
        a_hi  = (state == S_IDLE) ? '0 : cur_addr[ADDR_W-1:IO_ADDR_W];
        bhe_n = (state == S_IDLE) ? 1'b1 : lane_bhe_n;
        st_io = st_active && q_io;
        st_wr = st_active && q_wr;
    end

    // read data assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture) begin
            if (aligned_word)
                rd_q <= ad_in;
            else if (misal && !second)
                rd_q[LANE_W-1:0] <= rbyte;
            else if (misal)
                rd_q[BUS_W-1:LANE_W] <= rbyte;
            else
                rd_q <= {{LANE_W{1'b0}}, rbyte};
        end
    end

    assign rdata = rd_q;
    assign ack   = done;

    mbc_addr_latch #(
        .ADDR_W(ADDR_W),
        .LOW_W (IO_ADDR_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .hi_in    (a_hi),
        .low_in   (ad_out),
        .bhe_n_in (bhe_n),
        .lat_addr (lat_addr),
        .lat_bhe_n(lat_bhe_n)
    );

    p_strobe_after_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_io_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && st_io) |-> (a_hi == '0));

    p_lane_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(ad_out[0] && bhe_n));

    p_den_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n |-> (!rd_n || !wr_n));
endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0, req_io = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata, ad_out, ad_in;
    logic        ad_oe, bhe_n, ale, rd_n, wr_n, den_n, st_io, st_wr, ready;
    logic [3:0]  a_hi;
    logic [19:0] lat_addr;
    logic        lat_bhe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_io(req_io),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .st_io(st_io), .st_wr(st_wr), .ready(ready),
        .lat_addr(lat_addr), .lat_bhe_n(lat_bhe_n)
    );

    int tests = 0, fails = 0, cyc = 0;

    // two-bank device model and flat reference
    logic [7:0] mem_even [256];
    logic [7:0] mem_odd  [256];
    logic [7:0] ref_mem  [512];

    assign ad_in = !rd_n ? {mem_odd[lat_addr[8:1]], mem_even[lat_addr[8:1]]} : 16'hA5C3;

    always @(posedge clk) begin
        if (rst_n && !wr_n) begin
            if (!lat_addr[0]) mem_even[lat_addr[8:1]] <= ad_out[7:0];
            if (!lat_bhe_n)   mem_odd[lat_addr[8:1]]  <= ad_out[15:8];
        end
    end

    // ready: released after wait_n clocks of S_T3
    int wait_n = 0;
    int scnt = 0;
    always @(posedge clk) scnt <= (!rd_n || !wr_n) ? scnt + 1 : 0;
    assign ready = (scnt >= wait_n + 1);

    // bus cycle log
    int          lc = 0;
    int          ack_cnt = 0;
    logic [19:0] log_addr [4];
    logic        log_bhe [4], log_io [4], log_wr [4], log_ok2 [4];
    logic [15:0] log_w [4];
    int          log_slen [4];
    logic        bad4 = 1'b0, bad5 = 1'b0, bad13 = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (ack) ack_cnt <= ack_cnt + 1;
            if (ale) begin
                if (lc < 4) begin
                    log_addr[lc] <= {a_hi, ad_out};
                    log_bhe[lc]  <= bhe_n;
                    log_io[lc]   <= st_io;
                    log_wr[lc]   <= st_wr;
                    log_ok2[lc]  <= ad_oe && rd_n && wr_n && den_n;
                    log_slen[lc] <= 0;
                end
                lc <= lc + 1;
            end
            if ((!rd_n || !wr_n) && lc >= 1 && lc <= 4) begin
                log_slen[lc-1] <= log_slen[lc-1] + 1;
                if (!wr_n) log_w[lc-1] <= ad_out;
                if (lat_addr != log_addr[lc-1] || lat_bhe_n != log_bhe[lc-1]) bad5 <= 1'b1;
            end
            if ((!rd_n && ad_oe) || (!wr_n && !ad_oe) || (rd_n && wr_n && ad_oe && !ale)) bad4 <= 1'b1;
            if (den_n != (rd_n && wr_n)) bad13 <= 1'b1;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run(input bit wr, input bit io, input bit word, input logic [19:0] a,
                       input logic [15:0] d, input int w, input bit poke);
        logic [19:0] c0, c1;
        logic [15:0] wl0, wl1, exp_rd, got;
        int n, acks0;
        c0 = io ? {4'h0, a[15:0]} : a;
        c1 = io ? {4'h0, a[15:0] + 16'h1} : a + 20'h1;
        n = (word && a[0]) ? 2 : 1;
        wl0 = (word && !a[0]) ? d : {d[7:0], d[7:0]};
        wl1 = {d[15:8], d[15:8]};
        exp_rd = word ? {ref_mem[c1[8:0]], ref_mem[c0[8:0]]} : {8'h00, ref_mem[c0[8:0]]};
        @(negedge clk);
        lc = 0; bad4 = 0; bad5 = 0; bad13 = 0; acks0 = ack_cnt; wait_n = w;
        req = 1; req_wr = wr; req_io = io; req_word = word; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (poke) begin
            req_addr = a ^ 20'h00155; req_wr = !wr; req_wdata = ~d;
        end else req = 0;
        while (!ack) @(negedge clk);
        req = 0;
        got = rdata;
        @(negedge clk);
        chk("R11 single ack", {31'd0, ack}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R12 cycle count", lc, n);
        chk("R11 ack count", ack_cnt - acks0, 1);
        chk("R4 drive window", {31'd0, bad4}, 32'd0);
        chk("R5 latch", {31'd0, bad5}, 32'd0);
        chk("R13 den", {31'd0, bad13}, 32'd0);
        if (lc == n) begin
            for (int c = 0; c < n; c++) begin
                chk("R2 address phase", {31'd0, log_ok2[c]}, 32'd1);
                chk(c == 0 ? "R7 R10 addr first" : "R10 addr second", {12'd0, log_addr[c]}, {12'd0, c == 0 ? c0 : c1});
                chk("R7 bhe", {31'd0, log_bhe[c]}, {31'd0, (c == 0) ? !(word || a[0]) : 1'b1});
                chk("R6 status io", {30'd0, log_io[c], log_wr[c]}, {30'd0, io, wr});
                chk("R3 strobe length", log_slen[c], w + 2);
                if (wr) chk("R8 R10 write lanes", {16'd0, log_w[c]}, {16'd0, c == 0 ? wl0 : wl1});
            end
        end
        if (!wr) chk(word ? "R9 R10 read word" : "R9 read byte", {16'd0, got}, {16'd0, exp_rd});
        if (wr) begin
            ref_mem[c0[8:0]] = d[7:0];
            if (word) ref_mem[c1[8:0]] = d[15:8];
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem_even[i] = 8'(i * 74 + 11);
            mem_odd[i]  = 8'(i * 74 + 48);
            ref_mem[2*i]     = 8'(i * 74 + 11);
            ref_mem[2*i + 1] = 8'(i * 74 + 48);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 idle during reset", {26'd0, ale, ad_oe, ack, rd_n, wr_n, den_n}, {26'd0, 6'b000111});
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {25'd0, ale, ad_oe, ack, rd_n, wr_n, den_n, bhe_n}, {25'd0, 7'b0001111});
        // directed: every size x parity x direction, memory and I/O
        for (int k = 0; k < 16; k++)
            run(k[0], k[3], k[1], 20'h3A5C4 | {19'd0, k[2]}, 16'hC3E1 + 16'(k), k % 3, 1'b0);
        // wrap corners (R10, R6)
        run(1, 0, 1, 20'hFFFFF, 16'hBEEF, 0, 0);
        run(0, 0, 1, 20'hFFFFF, 16'h0000, 1, 0);
        run(1, 1, 1, 20'h7FFFF, 16'h1234, 0, 0);
        run(0, 1, 1, 20'h9FFFF, 16'h0000, 2, 0);
        // busy requests held (R12)
        run(0, 0, 1, 20'h00101, 16'h0, 1, 1);
        run(1, 0, 0, 20'h00202, 16'h5A5A, 0, 1);
        // constrained random
        for (int t = 0; t < 300; t++)
            run($urandom % 2, ($urandom % 4) == 0, $urandom % 2, 20'($urandom),
                16'($urandom), $urandom % 4, ($urandom % 6) == 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule